// File: doc/BRIEF.md
# Negative Delta-V Charge Termination Detector

This block decides when fast charging of a nickel cell ends. A charge controller sends it a start pulse when fast charge begins, a periodic tick from the charger timebase, and a stream of open-circuit cell-voltage codes, each marked by a one-cycle valid strobe. The block first waits out a hold-off window, measured in ticks. During that window no decision is taken and no sample is used. After the window it keeps the highest voltage seen so far. It raises a drop indication when a sample falls below that peak by the programmed threshold. It raises a flat indication when the peak has not risen for a set number of ticks.

The control is a six-state machine. IDLE waits for the first start. HOLDOFF counts ticks and ignores samples. ARM waits for the first sample and stores it as the peak. TRACK compares samples against the peak and counts flat ticks. DROP_DONE and FLAT_DONE are terminal, and their outputs stay set. The transitions are:
- start from any state goes to HOLDOFF.
- IDLE waits for start.
- HOLDOFF goes to ARM when the hold-off count is complete.
- ARM goes to TRACK on the first valid sample.
- TRACK goes to DROP_DONE on a sample that meets the drop rule. Otherwise it goes to FLAT_DONE when the flat count is complete.
- DROP_DONE and FLAT_DONE leave only on start.

Top module: `ndv_term_detect`

## Requirements
- R1: After reset both `term_drop_o` and `term_flat_o` are 0, and they stay 0 until the first start pulse has been taken.
- R2: A start pulse is accepted in any state. From the next cycle it clears both termination outputs and begins a fresh hold-off.
- R3: For HOLDOFF_TICKS ticks after start, valid samples are ignored. They neither load the peak nor cause any termination.
- R4: The first valid sample after hold-off becomes the peak and restarts the flat count. It cannot itself terminate.
- R5: In tracking, a sample strictly greater than the stored peak replaces the peak and restarts the flat count from zero.
- R6: In tracking, a sample that is not above the peak, with peak minus sample greater than or equal to `drop_thresh_i`, sets `term_drop_o` in the cycle after the strobe. Both values are unsigned codes.
- R7: In tracking, once FLAT_TICKS ticks have passed with no new peak, `term_flat_o` is set one cycle after the last such tick.
- R8: A sample equal to the peak neither restarts the flat count nor changes the peak.
- R9: A set termination output stays set until the next start pulse. Later samples and ticks do not clear it and do not raise the other output.
- R10: The two outputs are never high together. If a drop sample arrives in the same cycle that the flat count is complete, only `term_drop_o` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse at the beginning of fast charge |
| tick_i | input | 1 | One-cycle timebase pulse |
| sample_valid_i | input | 1 | Strobe marking a new voltage code |
| sample_i | input | VW | Unsigned cell-voltage code |
| drop_thresh_i | input | VW | Drop below peak needed for termination, in code units |
| term_drop_o | output | 1 | Sticky negative delta-V termination |
| term_flat_o | output | 1 | Sticky flat-voltage termination |

## Verification
The bench drives a low sample during hold-off, then sends a small sample after arming. A design that loaded the peak during hold-off would report a false drop. It counts flat ticks up to the limit around an equal sample and around a new peak. A timer cleared by equal samples would fire late. A timer not cleared by a new peak would fire early. It tests the drop exactly at the threshold, and a difference one code short of it, to catch an off-by-one comparison. It also lines up a drop sample with the flat expiry and sends samples after termination, which exposes wrong priority and outputs that are not sticky.

// File: rtl/ndv_pkg.sv
package ndv_pkg;
    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_HOLDOFF   = 3'd1,
        S_ARM       = 3'd2,
        S_TRACK     = 3'd3,
        S_DROP_DONE = 3'd4,
        S_FLAT_DONE = 3'd5
    } ndv_state_e;

    function automatic int cnt_width(input int limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction
endpackage

// File: rtl/ndv_tick_counter.sv
module ndv_tick_counter #(
    parameter int LIMIT = 240
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int CW = ndv_pkg::cnt_width(LIMIT);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (en_i && tick_i && (cnt_q < LIM)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = (cnt_q == LIM);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM); // R7

    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/ndv_peak_tracker.sv
module ndv_peak_tracker #(
    parameter int VW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          upd_i,
    input  logic [VW-1:0] sample_i,
    input  logic [VW-1:0] thresh_i,
    output logic          above_o,
    output logic          drop_o
);
    logic [VW-1:0] peak_q;
    logic [VW-1:0] diff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            peak_q <= '0;
        end else if (load_i || (upd_i && above_o)) begin
            peak_q <= sample_i;
        end
    end

    always_comb begin
        above_o = (sample_i > peak_q);
        diff    = peak_q - sample_i;
        drop_o  = !above_o && (diff >= thresh_i);
    end

    AST_PEAK_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> (peak_q >= $past(peak_q))); // R5

    AST_EQUAL_KEEPS_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && (sample_i == peak_q)) |=> $stable(peak_q)); // R8
endmodule

// File: rtl/ndv_term_detect.sv
module ndv_term_detect #(
    parameter int VW            = 12,
    parameter int HOLDOFF_TICKS = 240,
    parameter int FLAT_TICKS    = 960
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          tick_i,
    input  logic          sample_valid_i,
    input  logic [VW-1:0] sample_i,
    input  logic [VW-1:0] drop_thresh_i,
    output logic          term_drop_o,
    output logic          term_flat_o
);
    import ndv_pkg::*;

    ndv_state_e state_q, state_d;
    logic hold_done, flat_done;
    logic peak_load, peak_upd, above, drop_hit;
    logic flat_clr, in_track, in_hold;

    // control towards the datapath
    always_comb begin
        in_hold   = (state_q == S_HOLDOFF);
        in_track  = (state_q == S_TRACK);
        peak_load = !start_i && sample_valid_i && (state_q == S_ARM);
        peak_upd  = !start_i && sample_valid_i && in_track;
        flat_clr  = start_i || peak_load || (peak_upd && above);
    end

    ndv_tick_counter #(.LIMIT(HOLDOFF_TICKS)) u_hold (
        .clk(clk), .rst_n(rst_n), .clr_i(start_i), .en_i(in_hold),
        .tick_i(tick_i), .done_o(hold_done)
    );

    ndv_tick_counter #(.LIMIT(FLAT_TICKS)) u_flat (
        .clk(clk), .rst_n(rst_n), .clr_i(flat_clr), .en_i(in_track),
        .tick_i(tick_i), .done_o(flat_done)
    );

    ndv_peak_tracker #(.VW(VW)) u_peak (
        .clk(clk), .rst_n(rst_n), .load_i(peak_load), .upd_i(peak_upd),
        .sample_i(sample_i), .thresh_i(drop_thresh_i),
        .above_o(above), .drop_o(drop_hit)
    );

    // next state
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = S_HOLDOFF;
        end else begin
            unique case (state_q)
                S_IDLE:      state_d = S_IDLE;
                S_HOLDOFF:   if (hold_done) state_d = S_ARM;
                S_ARM:       if (sample_valid_i) state_d = S_TRACK;
                S_TRACK: begin
                    if (sample_valid_i && drop_hit) state_d = S_DROP_DONE;
                    else if (flat_done)             state_d = S_FLAT_DONE;
                end
                S_DROP_DONE: state_d = S_DROP_DONE;
                S_FLAT_DONE: state_d = S_FLAT_DONE;
                default:     state_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        term_drop_o = 1'b0;
        term_flat_o = 1'b0;
        unique case (state_q)
            S_DROP_DONE: term_drop_o = 1'b1;
            S_FLAT_DONE: term_flat_o = 1'b1;
            default: ;
        endcase
    end

    AST_EXCLUSIVE_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        !(term_drop_o && term_flat_o)); // R10

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!term_drop_o && !term_flat_o)); // R2

    AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (term_drop_o && !start_i) |=> term_drop_o); // R9

    AST_FLAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (term_flat_o && !start_i) |=> term_flat_o); // R9

    AST_DROP_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(term_drop_o) |-> $past(sample_valid_i)); // R6

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        in_hold |-> !$past(peak_load)); // R3
endmodule

// File: tb/ndv_term_detect_tb.sv
module ndv_term_detect_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int VW   = 12;
    localparam int HOLD = 8;
    localparam int FLAT = 16;
    localparam int NV   = 8;

    localparam logic [VW-1:0] VEC_SAMPLE [NV] =
        '{12'd100, 12'd110, 12'd120, 12'd118, 12'd116, 12'd120, 12'd115, 12'd130};
    localparam logic VEC_DROP [NV] =
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, tick = 1'b0, valid = 1'b0;
    logic [VW-1:0] sample = '0, thresh = 12'd5;
    logic term_drop, term_flat;
    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ndv_term_detect #(.VW(VW), .HOLDOFF_TICKS(HOLD), .FLAT_TICKS(FLAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .tick_i(tick),
        .sample_valid_i(valid), .sample_i(sample), .drop_thresh_i(thresh),
        .term_drop_o(term_drop), .term_flat_o(term_flat)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic do_tick();
        tick = 1'b1; @(negedge clk); tick = 1'b0;
    endtask

    task automatic send(input logic [VW-1:0] s);
        sample = s; valid = 1'b1; @(negedge clk); valid = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic arm();
        pulse_start();
        for (int i = 0; i < HOLD; i++) do_tick();
        idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R1 reset state, and samples before any start do nothing
        chk("R1 drop after reset", term_drop, 1'b0);
        chk("R1 flat after reset", term_flat, 1'b0);
        send(12'd0); send(12'd500);
        chk("R1 drop before start", term_drop, 1'b0);

        // table: R4 init, R5 peak, R6 threshold boundary, R9 sticky
        arm();
        for (int i = 0; i < NV; i++) begin
            send(VEC_SAMPLE[i]);
            chk($sformatf("R6 vector %0d", i), term_drop, VEC_DROP[i]);
        end
        chk("R9 flat stays low after drop", term_flat, 1'b0);

        // R2 start clears
        pulse_start();
        chk("R2 drop cleared by start", term_drop, 1'b0);

        // R3 hold-off ignores samples
        for (int i = 0; i < HOLD/2; i++) do_tick();
        send(12'd100); send(12'd50);
        chk("R3 no drop in holdoff", term_drop, 1'b0);
        for (int i = 0; i < HOLD - HOLD/2; i++) do_tick();
        idle();
        send(12'd60);
        chk("R4 first sample no drop", term_drop, 1'b0);
        send(12'd56);
        chk("R3 holdoff sample not peak", term_drop, 1'b0);

        // R7 and R8: equal sample does not restart flat count
        arm();
        send(12'd200);
        for (int i = 0; i < 10; i++) do_tick();
        send(12'd200);
        for (int i = 0; i < FLAT - 11; i++) do_tick();
        idle();
        chk("R8 flat before limit", term_flat, 1'b0);
        do_tick(); idle();
        chk("R7 flat at limit with equal sample", term_flat, 1'b1);
        send(12'd10);
        chk("R9 flat sticky", term_flat, 1'b1);
        chk("R9 no drop after flat", term_drop, 1'b0);

        // R5 new peak restarts the flat count
        arm();
        send(12'd200);
        for (int i = 0; i < 10; i++) do_tick();
        send(12'd201);
        for (int i = 0; i < FLAT - 1; i++) do_tick();
        idle();
        chk("R5 flat restarted by new peak", term_flat, 1'b0);
        do_tick(); idle();
        chk("R5 flat after full window", term_flat, 1'b1);

        // R10 drop wins over simultaneous flat expiry
        arm();
        send(12'd300);
        for (int i = 0; i < FLAT; i++) do_tick();
        send(12'd290);
        chk("R10 drop priority", term_drop, 1'b1);
        chk("R10 flat suppressed", term_flat, 1'b0);
        do_tick(); idle();
        chk("R10 flat stays low", term_flat, 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule